// File: doc/BRIEF.md
# Unified Conservative Load/Store Queue

This block tracks the memory operations of an out-of-order core in one circular queue. Loads and stores share it in program order. A slot is taken when an operation dispatches and is released when that operation retires. Address generation happens outside the block, in register dataflow order, so each slot's address (and a store's data) arrives on a resolution port at any time and in any order.

The queue schedules loads conservatively. A load is eligible only when its own address is known and every older store in the queue has a known address. An eligible load with no matching older store goes to the data cache as a request. If one or more older stores match its address, the load takes its data from the youngest of them instead. The decision comes from a pairwise comparison of every entry against every other, qualified by relative age. Stores never write memory early: a store's write is presented only when that store retires. A squash input cuts the queue back to a given slot after a misprediction.

Top module: `lsq_unified`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `disp_idx` is 0, and neither `ld_valid` nor `mem_wr_valid` is asserted.
- R2: A dispatch while not full takes the slot shown on `disp_idx`, and `disp_idx` then advances by one modulo DEPTH. `full` is 1 exactly when all DEPTH slots are occupied, and a dispatch while full is ignored.
- R3: `retire_valid` on a non-empty queue frees the oldest entry. If that entry is a store, `mem_wr_valid` is 1 in the same cycle with the store's address and data. A retiring load produces no write, and retire on an empty queue does nothing.
- R4: A load is presented on `ld_valid` only when its address is resolved and every older store in the queue has a resolved address.
- R5: An eligible load with no older store at the same address is presented as a cache request: `ld_fwd` is 0 and `ld_addr` is the load's address.
- R6: An eligible load with one or more older stores at the same address is presented with `ld_fwd` equal to 1, and `ld_data` holds the data of the youngest such store that is still older than the load.
- R7: Stores younger than a load neither hold it back nor supply its data.
- R8: At most one load is presented per cycle, and it is the oldest eligible one. A load that has been presented once is never presented again.
- R9: `squash_valid` with an occupied `squash_idx` invalidates every entry younger than that slot, and the next `disp_idx` is `squash_idx`+1. A dispatch in the same cycle is ignored. A squash naming an unoccupied slot is ignored.
- R10: A resolution naming an unoccupied slot changes nothing. A resolution to an occupied slot sets its address (and a store's data), and may arrive in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch a new operation |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| full | output | 1 | All slots occupied |
| disp_idx | output | IDX_W | Slot the next dispatch takes |
| res_valid | input | 1 | Address resolution strobe |
| res_idx | input | IDX_W | Slot being resolved |
| res_addr | input | AW | Resolved address |
| res_data | input | DW | Store data (ignored for loads) |
| ld_valid | output | 1 | A load is presented this cycle |
| ld_idx | output | IDX_W | Slot of the presented load |
| ld_addr | output | AW | Address of the presented load |
| ld_fwd | output | 1 | 1 = forwarded from a store, 0 = cache request |
| ld_data | output | DW | Forwarded data (0 when not forwarding) |
| retire_valid | input | 1 | Retire the oldest entry |
| mem_wr_valid | output | 1 | Retiring store writes memory |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| squash_valid | input | 1 | Discard entries younger than squash_idx |
| squash_idx | input | IDX_W | Youngest slot that survives |

## Verification
A wrong head or occupancy count shows within one cycle on `disp_idx` or `full`, or as a wrong address on `mem_wr_*` when the next store retires. A stale or missed address bit shows as a load presented too early, or one held back, in the first cycle after the blocking store resolves. A wrong age comparison shows as forwarded data from the wrong store or as a younger store stealing a load. The bench keeps a plain ordered model of the queue and compares every output on every cycle, so any divergence is reported in the cycle it first reaches the ports.

// File: rtl/lsq_pkg.sv
// Shared types for the unified load/store queue.
// Assumes: nothing beyond SystemVerilog packed structs.
package lsq_pkg;
    // Per-slot status bits.
    typedef struct packed {
        logic valid;     // slot occupied
        logic is_store;  // 1 = store, 0 = load
        logic addr_ok;   // address (and store data) resolved
        logic done;      // load already presented
    } lsq_flags_t;
endpackage

// File: rtl/lsq_ptr_ctrl.sv
// Head pointer and occupancy count of the circular queue; the tail is derived.
// Assumes: DEPTH is a power of two; squash_ok is only raised for an occupied slot.
module lsq_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_req,
    input  logic             retire_req,
    input  logic             squash_ok,
    input  logic [IDX_W-1:0] squash_idx,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             disp_ok,
    output logic             ret_ok
);
    logic [IDX_W:0]   count_q, count_nxt;
    logic [IDX_W-1:0] head_q, sq_age;

    assign head    = head_q;
    assign tail    = head_q + count_q[IDX_W-1:0];
    assign full    = (count_q == (IDX_W+1)'(DEPTH));
    assign ret_ok  = retire_req && (count_q != '0);
    assign disp_ok = disp_req && !full && !squash_ok;
    assign sq_age  = squash_idx - head_q;

    // Next occupancy: a squash keeps the head up to and including the squash slot.
    always_comb begin
        if (squash_ok)
            count_nxt = (IDX_W+1)'(sq_age) + 1'b1 - (IDX_W+1)'(ret_ok);
        else
            count_nxt = count_q + (IDX_W+1)'(disp_ok) - (IDX_W+1)'(ret_ok);
    end

    // Pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_q + IDX_W'(ret_ok);
            count_q <= count_nxt;
        end
    end

    // R2: a full queue stays full when nothing leaves.
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        full && !retire_req && !squash_ok |=> full);

    // R9: after a squash the next free slot follows the squash slot.
    a_r9_squash_tail: assert property (@(posedge clk) disable iff (!rst_n)
        squash_ok |=> tail == IDX_W'($past(squash_idx) + 1'b1));
endmodule

// File: rtl/lsq_match_matrix.sv
// Pairwise address/age comparison: for each load, whether any older store is
// still unresolved, and which older matching store is the youngest.
// Assumes: ages are measured from head, so a smaller age is older.
module lsq_match_matrix
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] head,
    input  lsq_flags_t       fl     [DEPTH],
    input  logic [AW-1:0]    addr   [DEPTH],
    output logic [DEPTH-1:0] ready,
    output logic [DEPTH-1:0] fwd_hit,
    output logic [IDX_W-1:0] fwd_idx [DEPTH]
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        logic             blocked, hit;
        logic [IDX_W-1:0] best, best_age, age_i, age_j;

        // Row i of the matrix: compare load i against every other slot j.
        always_comb begin
            blocked = 1'b0;
            hit     = 1'b0;
            best    = '0;
            best_age = '0;
            age_i   = IDX_W'(i) - head;
            age_j   = '0;
            for (int j = 0; j < DEPTH; j++) begin
                age_j = IDX_W'(j) - head;
                if (fl[j].valid && fl[j].is_store && (age_j < age_i)) begin
                    if (!fl[j].addr_ok)
                        blocked = 1'b1;
                    else if ((addr[j] == addr[i]) && (!hit || (age_j > best_age))) begin
                        hit      = 1'b1;
                        best     = IDX_W'(j);
                        best_age = age_j;
                    end
                end
            end
            ready[i]   = fl[i].valid && !fl[i].is_store && fl[i].addr_ok &&
                         !fl[i].done && !blocked;
            fwd_hit[i] = hit;
            fwd_idx[i] = best;
        end
    end
endmodule

// File: rtl/lsq_oldest_pick.sv
// Chooses the oldest ready slot, scanning from head in queue order.
// Assumes: ready is already qualified by occupancy.
module lsq_oldest_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] head,
    input  logic [DEPTH-1:0] ready,
    output logic             pick_valid,
    output logic [IDX_W-1:0] pick_idx
);
    logic [IDX_W-1:0] slot;

    // First ready slot at or after head wins.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        slot       = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head + IDX_W'(k);
            if (!pick_valid && ready[slot]) begin
                pick_valid = 1'b1;
                pick_idx   = slot;
            end
        end
    end
endmodule

// File: rtl/lsq_unified.sv
// Unified conservative load/store queue: allocation at dispatch, out-of-order
// address resolution, age-qualified load scheduling with store forwarding,
// in-order retirement with store writes, and squash to a slot.
// Assumes: DEPTH is a power of two; retiring stores have resolved addresses.
module lsq_unified
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             disp_is_store,
    output logic             full,
    output logic [IDX_W-1:0] disp_idx,
    input  logic             res_valid,
    input  logic [IDX_W-1:0] res_idx,
    input  logic [AW-1:0]    res_addr,
    input  logic [DW-1:0]    res_data,
    output logic             ld_valid,
    output logic [IDX_W-1:0] ld_idx,
    output logic [AW-1:0]    ld_addr,
    output logic             ld_fwd,
    output logic [DW-1:0]    ld_data,
    input  logic             retire_valid,
    output logic             mem_wr_valid,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wr_data,
    input  logic             squash_valid,
    input  logic [IDX_W-1:0] squash_idx
);
    lsq_flags_t       fl      [DEPTH];
    logic [AW-1:0]    addr_q  [DEPTH];
    logic [DW-1:0]    data_q  [DEPTH];
    logic [IDX_W-1:0] fwd_idx [DEPTH];
    logic [IDX_W-1:0] head, tail, pick_idx, sq_age, e_age;
    logic [DEPTH-1:0] ready, fwd_hit, kill;
    logic             disp_ok, ret_ok, sq_ok, pick_valid;

    assign sq_ok = squash_valid && fl[squash_idx].valid;

    lsq_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk(clk), .rst_n(rst_n), .disp_req(disp_valid), .retire_req(retire_valid),
        .squash_ok(sq_ok), .squash_idx(squash_idx), .head(head), .tail(tail),
        .full(full), .disp_ok(disp_ok), .ret_ok(ret_ok)
    );

    lsq_match_matrix #(.DEPTH(DEPTH), .AW(AW)) mtx_i (
        .head(head), .fl(fl), .addr(addr_q), .ready(ready),
        .fwd_hit(fwd_hit), .fwd_idx(fwd_idx)
    );

    lsq_oldest_pick #(.DEPTH(DEPTH)) pick_i (
        .head(head), .ready(ready), .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    // Slots younger than the squash slot are dropped.
    always_comb begin
        sq_age = squash_idx - head;
        e_age  = '0;
        for (int e = 0; e < DEPTH; e++) begin
            e_age   = IDX_W'(e) - head;
            kill[e] = sq_ok && fl[e].valid && (e_age > sq_age);
        end
    end

    // Per-slot state: resolve, mark presented, allocate, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                fl[e]     <= '0;
                addr_q[e] <= '0;
                data_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (res_valid && (res_idx == IDX_W'(e)) && fl[e].valid) begin
                    addr_q[e]     <= res_addr;
                    data_q[e]     <= res_data;
                    fl[e].addr_ok <= 1'b1;
                end
                if (pick_valid && (pick_idx == IDX_W'(e)))
                    fl[e].done <= 1'b1;
                if (disp_ok && (tail == IDX_W'(e)))
                    fl[e] <= '{valid: 1'b1, is_store: disp_is_store, addr_ok: 1'b0, done: 1'b0};
                if ((ret_ok && (head == IDX_W'(e))) || kill[e])
                    fl[e].valid <= 1'b0;
            end
        end
    end

    assign disp_idx     = tail;
    assign ld_valid     = pick_valid;
    assign ld_idx       = pick_idx;
    assign ld_addr      = addr_q[pick_idx];
    assign ld_fwd       = pick_valid && fwd_hit[pick_idx];
    assign ld_data      = ld_fwd ? data_q[fwd_idx[pick_idx]] : '0;
    assign mem_wr_valid = ret_ok && fl[head].is_store;
    assign mem_wr_addr  = addr_q[head];
    assign mem_wr_data  = data_q[head];

    // R8: a presented load is marked and not presented again next cycle.
    a_r8_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !(ld_valid && (ld_idx == $past(ld_idx))));

    // R4: the picked slot is an occupied, resolved load.
    a_r4_pick_is_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> fl[ld_idx].valid && !fl[ld_idx].is_store && fl[ld_idx].addr_ok);

    // R6: the forwarding source is an older store at the same address.
    a_r6_fwd_source: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> fl[fwd_idx[ld_idx]].is_store && (addr_q[fwd_idx[ld_idx]] == ld_addr) &&
                   ((fwd_idx[ld_idx] - head) < (ld_idx - head)));

    // R3: a store written at retirement carries a resolved address.
    a_r3_write_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> fl[head].addr_ok);
endmodule

// File: tb/lsq_unified_tb.sv
`timescale 1ns/1ps
module lsq_unified_tb_top;
    localparam int D  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 0, disp_is_store = 0, res_valid = 0, retire_valid = 0, squash_valid = 0;
    logic [IW-1:0] res_idx = '0, squash_idx = '0;
    logic [15:0] res_addr = '0, res_data = '0;
    logic full, ld_valid, ld_fwd, mem_wr_valid;
    logic [IW-1:0] disp_idx, ld_idx;
    logic [15:0] ld_addr, ld_data, mem_wr_addr, mem_wr_data;

    int checks = 0, fails = 0;
    string phase = "R1";

    // Reference model state.
    int  m_head, m_cnt;
    bit  m_st[D], m_known[D], m_done[D];
    int  m_addr[D], m_data[D];

    always #10 clk = ~clk;

    lsq_unified #(.DEPTH(D), .AW(16), .DW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_store(disp_is_store),
        .full(full), .disp_idx(disp_idx), .res_valid(res_valid), .res_idx(res_idx),
        .res_addr(res_addr), .res_data(res_data), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_addr(ld_addr), .ld_fwd(ld_fwd), .ld_data(ld_data), .retire_valid(retire_valid),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .squash_valid(squash_valid), .squash_idx(squash_idx)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", req, phase, what, act, exp);
        end
    endtask

    function automatic int age(input int x);
        return (x - m_head + D) % D;
    endfunction

    // Apply one cycle of stimulus, compare against the model, then advance it.
    task automatic step(input bit dv, input bit ds, input bit rv, input int ri, input int ra,
                        input int rd, input bit retv, input bit sqv, input int sqi);
        bit e_pv, e_fwd, sq_ok, ret_ok, disp_ok;
        int e_pi, e_data, sq_age, t;
        disp_valid = dv; disp_is_store = ds;
        res_valid = rv; res_idx = IW'(ri); res_addr = 16'(ra); res_data = 16'(rd);
        retire_valid = retv; squash_valid = sqv; squash_idx = IW'(sqi);
        #1;
        e_pv = 0; e_pi = 0; e_fwd = 0; e_data = 0;
        for (int k = 0; k < m_cnt && !e_pv; k++) begin
            int s = (m_head + k) % D;
            bit blk = 0, hit = 0;
            int hd = 0;
            if (m_st[s] || !m_known[s] || m_done[s]) continue;
            for (int m = 0; m < k; m++) begin
                int o = (m_head + m) % D;
                if (!m_st[o]) continue;
                if (!m_known[o]) blk = 1;
                else if (m_addr[o] == m_addr[s]) begin hit = 1; hd = m_data[o]; end
            end
            if (!blk) begin e_pv = 1; e_pi = s; e_fwd = hit; e_data = hd; end
        end
        chk("R2", "full", int'(full), int'(m_cnt == D));
        chk("R2", "disp_idx", int'(disp_idx), (m_head + m_cnt) % D);
        chk("R4", "ld_valid", int'(ld_valid), int'(e_pv));
        if (ld_valid && e_pv) begin
            chk("R8", "ld_idx", int'(ld_idx), e_pi);
            chk("R5", "ld_fwd", int'(ld_fwd), int'(e_fwd));
            chk("R5", "ld_addr", int'(ld_addr), m_addr[e_pi]);
            if (e_fwd) chk("R6", "ld_data", int'(ld_data), e_data);
        end
        ret_ok = retv && (m_cnt > 0);
        chk("R3", "mem_wr_valid", int'(mem_wr_valid), int'(ret_ok && m_st[m_head]));
        if (mem_wr_valid && ret_ok && m_st[m_head]) begin
            chk("R3", "mem_wr_addr", int'(mem_wr_addr), m_addr[m_head]);
            chk("R3", "mem_wr_data", int'(mem_wr_data), m_data[m_head]);
        end
        @(posedge clk);
        if (e_pv) m_done[e_pi] = 1;
        if (rv && age(ri) < m_cnt) begin
            m_addr[ri] = ra & 16'hFFFF; m_data[ri] = rd & 16'hFFFF; m_known[ri] = 1;
        end
        sq_age  = age(sqi);
        sq_ok   = sqv && (sq_age < m_cnt);
        disp_ok = dv && (m_cnt < D) && !sq_ok;
        if (disp_ok) begin
            t = (m_head + m_cnt) % D;
            m_st[t] = ds; m_known[t] = 0; m_done[t] = 0;
        end
        if (sq_ok) m_cnt = sq_age + 1;
        else if (disp_ok) m_cnt++;
        if (ret_ok) begin m_head = (m_head + 1) % D; m_cnt--; end
        @(negedge clk);
        disp_valid = 0; res_valid = 0; retire_valid = 0; squash_valid = 0;
        #1;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        m_head = 0; m_cnt = 0;
        for (int i = 0; i < D; i++) begin
            m_st[i] = 0; m_known[i] = 0; m_done[i] = 0; m_addr[i] = 0; m_data[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "full", int'(full), 0);
        chk("R1", "disp_idx", int'(disp_idx), 0);
        chk("R1", "ld_valid", int'(ld_valid), 0);
        chk("R1", "mem_wr_valid", int'(mem_wr_valid), 0);

        // R2: dispatch S0 L1 S2 L3 L4 S5
        phase = "R2";
        step(1, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0);

        // R4 / R10: out-of-order resolution; loads wait for S0
        phase = "R4";
        step(0, 0, 1, 1, 'h30, 0, 0, 0, 0);
        chk("R4", "L1 waits for unresolved older store", int'(ld_valid), 0);
        step(0, 0, 1, 4, 'h60, 0, 0, 0, 0);
        step(0, 0, 1, 5, 'h60, 'h5555, 0, 0, 0);
        step(0, 0, 1, 2, 'h30, 'hBBBB, 0, 0, 0);
        step(0, 0, 1, 3, 'h30, 0, 0, 0, 0);
        chk("R4", "loads still wait for S0", int'(ld_valid), 0);
        step(0, 0, 1, 0, 'h30, 'hAAAA, 0, 0, 0);

        // R6 / R8: oldest first, youngest older matching store supplies data
        phase = "R6";
        chk("R8", "oldest eligible load first", int'(ld_idx), 1);
        chk("R6", "L1 forwards from S0", int'(ld_data), 'hAAAA);
        idle();
        chk("R8", "next load presented", int'(ld_idx), 3);
        chk("R6", "L3 forwards from youngest older S2", int'(ld_data), 'hBBBB);
        idle();
        // R7: younger store S5 at the same address is ignored
        phase = "R7";
        chk("R7", "L4 goes to cache", int'(ld_fwd), 0);
        chk("R7", "L4 presented", int'(ld_idx), 4);
        idle();
        chk("R8", "nothing left to present", int'(ld_valid), 0);

        // R2: fill and dispatch while full
        phase = "R2";
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R2", "full after DEPTH dispatches", int'(full), 1);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R2", "dispatch while full ignored", int'(disp_idx), 0);

        // R3: retire five entries, stores write
        phase = "R3";
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R3", "slot freed", int'(full), 0);

        // R9: squash to slot 5 with a dispatch in the same cycle
        phase = "R9";
        step(1, 0, 0, 0, 0, 0, 0, 1, 5);
        chk("R9", "tail follows squash slot", int'(disp_idx), 6);

        // R10: resolution to an unoccupied slot
        phase = "R10";
        step(0, 0, 1, 7, 'h60, 'h1234, 0, 0, 0);
        chk("R10", "no load after stray resolution", int'(ld_valid), 0);
        chk("R10", "tail unchanged", int'(disp_idx), 6);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 6, 'h60, 0, 0, 0, 0);
        chk("R6", "L6 forwards from S5", int'(ld_data), 'h5555);
        idle();
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", "new load at slot 7 not resolved", int'(ld_valid), 0);

        // Mixed traffic compared against the model every cycle.
        phase = "mixed R2 R3 R4 R5 R6 R8 R9 R10";
        for (int c = 0; c < 3000; c++) begin
            bit dv, ds, rv, retv, sqv;
            int ri, ra, rd, sqi, h;
            h    = m_head;
            dv   = ($urandom_range(0, 3) != 0);
            ds   = $urandom_range(0, 1);
            rv   = $urandom_range(0, 1);
            ri   = $urandom_range(0, D - 1);
            ra   = 'h10 * $urandom_range(1, 4);
            rd   = $urandom_range(0, 'hFFFF);
            retv = (m_cnt > 0) && (m_st[h] ? m_known[h] : m_done[h]) && ($urandom_range(0, 2) != 0);
            sqv  = (m_cnt > 0) && ($urandom_range(0, 24) == 0);
            sqi  = (m_cnt > 0) ? (h + $urandom_range(0, m_cnt - 1)) % D : 0;
            if ($urandom_range(0, 9) == 0) sqi = $urandom_range(0, D - 1);
            step(dv, ds, rv, ri, ra, rd, retv, sqv, sqi);
        end

        summary();
        $finish;
    end
endmodule